// File: doc/BRIEF.md
# Event-Driven Tapped Shift Register Channel

This block is one timer channel working as an event-driven shift register. A register of `W` bits moves one place toward the LSB on each qualified shift event, and a serial bit enters at the MSB. Each of the five control pins (start, reload, stop, shift, serial) has its own qualifier. The qualifier samples the pin once per clock and compares it with the value it held at the previous prescaled tick. It then reports a rising, falling or either edge, a high level, or nothing. A power-of-two prescaler sets how often those qualifiers are consulted.

A tap mask selects register bits, and their XOR drives a line output and its complement, each with its own polarity control. Two compare units watch every register update. Each one pulses on a match, can raise an interrupt, and can exchange its compare value with a buffered value at that match. Two trigger outputs each pick one event source. While the channel is disabled, its outputs follow a programmable idle drive. The configuration arrives on plain input ports from a surrounding register file, and `cfg_wr` loads the compare and buffer values.

Top module: `srt_shift_timer`

## Requirements
- R1: While `rst` is high, at the next clock `count_o` becomes 0, the channel stops running, `hit_o` becomes 0 and the held idle line values become 0.
- R2: A tick occurs once every 2^`cfg_div` clocks while `en` is high. Input pins are qualified only on ticks, so with `cfg_div`=2 shifts happen at most every fourth clock.
- R3: A shift event while running sets `count_o` to {serial bit, `count_o`[W-1:1]}. The serial bit is the qualified serial pin: its level in mode 4, 1 only on the selected edge in modes 1 to 3, and 0 in mode 0.
- R4: Qualifier mode codes are 0 off, 1 rising, 2 falling, 3 either edge and 4 high level. Codes 5 to 7 act as off. An edge is measured against the pin value stored at the previous tick.
- R5: A reload event clears `count_o` to 0 and starts running. A start event starts running from the held value. On the start and reload pins, mode code 4 acts as off.
- R6: A stop event halts shifting. When stop and reload are qualified on the same tick, stop wins and the register is not cleared.
- R7: `hit_o[k]` is high for one clock after an update (reload or shift) whose new value equals compare k. `irq_o[k]` is `hit_o[k]` gated by `cfg_irq_en[k]`.
- R8: If `cfg_swap[k]` is set, the compare and buffer values of unit k exchange at each match. `cfg_wr` loads both values and takes precedence over a swap.
- R9: `line_o` is the XOR of the register bits selected by `cfg_taps`, inverted when `cfg_inv_line` is set. `compl_o` is the inverse of that XOR, inverted when `cfg_inv_compl` is set.
- R10: While `en` is low, the outputs follow `cfg_idle`: 0 gives no drive (`*_oe` low, data 0), 1 holds the last enabled values, 2 drives low and 3 drives high.
- R11: `trig_o[k]` follows its selector: 0 gives low, 1 gives `hit_o[0]`, 2 gives `hit_o[1]` and 3 gives `line_o`.
- R12: While `en` is low, `count_o` holds its value, the channel stops running and no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| cfg_wr | input | 1 | Loads compare and buffer values |
| cfg_div | input | DIV_BITS | Prescaler exponent |
| cfg_taps | input | W | Tap mask |
| cfg_cmp0 | input | W | Compare 0 load value |
| cfg_buf0 | input | W | Buffer 0 load value |
| cfg_cmp1 | input | W | Compare 1 load value |
| cfg_buf1 | input | W | Buffer 1 load value |
| cfg_swap | input | 2 | Swap enable per compare unit |
| cfg_irq_en | input | 2 | Interrupt enable per compare unit |
| cfg_inv_line | input | 1 | Invert line output |
| cfg_inv_compl | input | 1 | Invert complementary output |
| cfg_mode_start | input | 3 | Start qualifier mode |
| cfg_mode_reload | input | 3 | Reload qualifier mode |
| cfg_mode_stop | input | 3 | Stop qualifier mode |
| cfg_mode_shift | input | 3 | Shift qualifier mode |
| cfg_mode_serial | input | 3 | Serial qualifier mode |
| cfg_idle | input | 2 | Output drive while disabled |
| cfg_trig0 | input | 2 | Trigger 0 source |
| cfg_trig1 | input | 2 | Trigger 1 source |
| pin_start | input | 1 | Start pin |
| pin_reload | input | 1 | Reload pin |
| pin_stop | input | 1 | Stop pin |
| pin_shift | input | 1 | Shift pin |
| pin_serial | input | 1 | Serial data pin |
| count_o | output | W | Register value |
| line_o | output | 1 | Line output |
| line_oe | output | 1 | Line drive enable |
| compl_o | output | 1 | Complementary line output |
| compl_oe | output | 1 | Complementary drive enable |
| hit_o | output | 2 | Compare match pulses |
| irq_o | output | 2 | Interrupt pulses |
| trig_o | output | 2 | Trigger outputs |

## Verification
The bench builds the channel with `W`=16 and `DIV_BITS`=3. With that width, a run of set serial bits moves the register through values such as 16'h8000, 16'hC000 and 16'hFFFF within a few ticks. This lets matches, repeated swaps and back-to-back hits be reached quickly. Prescaler exponents 0 to 3 are driven, so tick spacings of 1, 2, 4 and 8 clocks and edges seen across skipped clocks are covered. Random phases also drive the unused mode codes 5 to 7.

// File: rtl/srt_pkg.sv
package srt_pkg;

    typedef enum logic [2:0] {
        QM_OFF   = 3'd0,
        QM_RISE  = 3'd1,
        QM_FALL  = 3'd2,
        QM_BOTH  = 3'd3,
        QM_LEVEL = 3'd4
    } qual_mode_e;

    typedef enum logic [1:0] {
        OD_HIZ  = 2'd0,
        OD_HOLD = 2'd1,
        OD_LOW  = 2'd2,
        OD_HIGH = 2'd3
    } idle_drive_e;

    typedef enum logic [1:0] {
        TS_NONE = 2'd0,
        TS_HIT0 = 2'd1,
        TS_HIT1 = 2'd2,
        TS_LINE = 2'd3
    } trig_src_e;

    localparam int NUM_IN    = 5;
    localparam int IN_START  = 0;
    localparam int IN_RELOAD = 1;
    localparam int IN_STOP   = 2;
    localparam int IN_SHIFT  = 3;
    localparam int IN_SERIAL = 4;

    typedef struct packed {
        logic line;
        logic compl;
    } line_pair_t;

    // event value of one pin given its mode, current sample and tick-stored sample
    function automatic logic qualify(input logic [2:0] mode, input logic cur, input logic prv);
        case (mode)
            QM_RISE:  return cur & ~prv;
            QM_FALL:  return ~cur & prv;
            QM_BOTH:  return cur ^ prv;
            QM_LEVEL: return cur;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic pick_trig(input logic [1:0] sel, input logic [1:0] hits, input logic line);
        case (sel)
            TS_HIT0: return hits[0];
            TS_HIT1: return hits[1];
            TS_LINE: return line;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/srt_tick.sv
module srt_tick #(
    parameter int DIV_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [DIV_BITS-1:0] div,
    output logic                tick
);
    localparam int CW = (1 << DIV_BITS) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;

    always_comb begin
        for (int i = 0; i < CW; i++) begin
            mask[i] = (i < int'(div));
        end
    end

    assign tick = en && ((cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/srt_qual.sv
module srt_qual
    import srt_pkg::*;
#(
    parameter bit ALLOW_LEVEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic [2:0] mode,
    input  logic       pin,
    output logic       evt
);
    logic       smp_q;
    logic       prv_q;
    logic [2:0] eff_mode;

    assign eff_mode = (!ALLOW_LEVEL && mode == QM_LEVEL) ? QM_OFF : mode;
    assign evt      = tick && qualify(eff_mode, smp_q, prv_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= 1'b0;
            prv_q <= 1'b0;
        end else begin
            smp_q <= pin;
            if (!en || tick) begin
                prv_q <= smp_q;
            end
        end
    end
endmodule

// File: rtl/srt_cmp.sv
module srt_cmp #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_cmp,
    input  logic [W-1:0] ld_buf,
    input  logic         swap_en,
    input  logic         upd,
    input  logic [W-1:0] nxt,
    output logic         hit
);
    logic [W-1:0] cmp_q;
    logic [W-1:0] buf_q;
    logic         match;

    assign match = upd && (nxt == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            buf_q <= '0;
            hit   <= 1'b0;
        end else begin
            hit <= match;
            if (load) begin
                cmp_q <= ld_cmp;
                buf_q <= ld_buf;
            end else if (match && swap_en) begin
                cmp_q <= buf_q;
                buf_q <= cmp_q;
            end
        end
    end
endmodule

// File: rtl/srt_shift_timer.sv
module srt_shift_timer
    import srt_pkg::*;
#(
    parameter int W        = 16,
    parameter int DIV_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                cfg_wr,
    input  logic [DIV_BITS-1:0] cfg_div,
    input  logic [W-1:0]        cfg_taps,
    input  logic [W-1:0]        cfg_cmp0,
    input  logic [W-1:0]        cfg_buf0,
    input  logic [W-1:0]        cfg_cmp1,
    input  logic [W-1:0]        cfg_buf1,
    input  logic [1:0]          cfg_swap,
    input  logic [1:0]          cfg_irq_en,
    input  logic                cfg_inv_line,
    input  logic                cfg_inv_compl,
    input  logic [2:0]          cfg_mode_start,
    input  logic [2:0]          cfg_mode_reload,
    input  logic [2:0]          cfg_mode_stop,
    input  logic [2:0]          cfg_mode_shift,
    input  logic [2:0]          cfg_mode_serial,
    input  logic [1:0]          cfg_idle,
    input  logic [1:0]          cfg_trig0,
    input  logic [1:0]          cfg_trig1,
    input  logic                pin_start,
    input  logic                pin_reload,
    input  logic                pin_stop,
    input  logic                pin_shift,
    input  logic                pin_serial,
    output logic [W-1:0]        count_o,
    output logic                line_o,
    output logic                line_oe,
    output logic                compl_o,
    output logic                compl_oe,
    output logic [1:0]          hit_o,
    output logic [1:0]          irq_o,
    output logic [1:0]          trig_o
);
    localparam int NCMP = 2;

    logic              tick;
    logic [NUM_IN-1:0] pins;
    logic [NUM_IN-1:0] evt;
    logic [2:0]        modes [NUM_IN];
    logic [W-1:0]      reg_q, nxt;
    logic              run_q, run_d, upd;
    logic [NCMP-1:0]   hit_w;
    logic [W-1:0]      ld_cmp [NCMP];
    logic [W-1:0]      ld_buf [NCMP];
    line_pair_t        live, hold_q, drv;
    logic              drv_oe;
    logic              tap_xor;

    assign pins = {pin_serial, pin_shift, pin_stop, pin_reload, pin_start};

    always_comb begin
        modes[IN_START]  = cfg_mode_start;
        modes[IN_RELOAD] = cfg_mode_reload;
        modes[IN_STOP]   = cfg_mode_stop;
        modes[IN_SHIFT]  = cfg_mode_shift;
        modes[IN_SERIAL] = cfg_mode_serial;
    end

    srt_tick #(.DIV_BITS(DIV_BITS)) u_tick (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .div (cfg_div),
        .tick(tick)
    );

    // level mode is honoured only from the stop pin upward
    generate
        for (genvar g = 0; g < NUM_IN; g++) begin : g_in
            srt_qual #(.ALLOW_LEVEL(g >= IN_STOP)) u_qual (
                .clk (clk),
                .rst (rst),
                .en  (en),
                .tick(tick),
                .mode(modes[g]),
                .pin (pins[g]),
                .evt (evt[g])
            );
        end
    endgenerate

    // priority: disable, stop, reload, start, shift
    always_comb begin
        nxt   = reg_q;
        upd   = 1'b0;
        run_d = run_q;
        if (!en) begin
            run_d = 1'b0;
        end else if (evt[IN_STOP]) begin
            run_d = 1'b0;
        end else if (evt[IN_RELOAD]) begin
            nxt   = '0;
            run_d = 1'b1;
            upd   = 1'b1;
        end else if (evt[IN_START]) begin
            run_d = 1'b1;
        end else if (run_q && evt[IN_SHIFT]) begin
            nxt = {evt[IN_SERIAL], reg_q[W-1:1]};
            upd = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
            run_q <= 1'b0;
        end else begin
            reg_q <= nxt;
            run_q <= run_d;
        end
    end

    assign ld_cmp[0] = cfg_cmp0;
    assign ld_buf[0] = cfg_buf0;
    assign ld_cmp[1] = cfg_cmp1;
    assign ld_buf[1] = cfg_buf1;

    generate
        for (genvar k = 0; k < NCMP; k++) begin : g_cmp
            srt_cmp #(.W(W)) u_cmp (
                .clk    (clk),
                .rst    (rst),
                .load   (cfg_wr),
                .ld_cmp (ld_cmp[k]),
                .ld_buf (ld_buf[k]),
                .swap_en(cfg_swap[k]),
                .upd    (upd),
                .nxt    (nxt),
                .hit    (hit_w[k])
            );
        end
    endgenerate

    assign tap_xor    = ^(reg_q & cfg_taps);
    assign live.line  = tap_xor ^ cfg_inv_line;
    assign live.compl = ~tap_xor ^ cfg_inv_compl;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (en) begin
            hold_q <= live;
        end
    end

    always_comb begin
        drv    = live;
        drv_oe = 1'b1;
        if (!en) begin
            case (cfg_idle)
                OD_HIZ: begin
                    drv    = '0;
                    drv_oe = 1'b0;
                end
                OD_HOLD: drv = hold_q;
                OD_LOW:  drv = '0;
                default: drv = '1;
            endcase
        end
    end

    assign count_o  = reg_q;
    assign line_o   = drv.line;
    assign compl_o  = drv.compl;
    assign line_oe  = drv_oe;
    assign compl_oe = drv_oe;
    assign hit_o    = hit_w;
    assign irq_o    = hit_w & cfg_irq_en;
    assign trig_o   = {pick_trig(cfg_trig1, hit_w, drv.line), pick_trig(cfg_trig0, hit_w, drv.line)};

endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
    parameter int W        = 16,
    parameter int DIV_BITS = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                en,
    input logic [DIV_BITS-1:0] cfg_div,
    input logic [1:0]          cfg_idle,
    input logic                tick,
    input logic [W-1:0]        count_o,
    input logic                line_o,
    input logic [1:0]          hit_w,
    input logic                upd,
    input logic                run_q
);
    // R12: a disabled channel leaves the register untouched
    assert_frozen_when_off_R12: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count_o));

    // R12: running can only begin while enabled
    assert_run_needs_en_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> $past(en));

    // R3 / R5: every change is either a clear or a one-place right shift
    assert_change_shape_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_o) |-> (count_o == '0 || count_o[W-2:0] == $past(count_o[W-1:1])));

    // R7: a compare pulse follows a register update
    assert_hit0_after_update_R7: assert property (@(posedge clk) disable iff (rst)
        hit_w[0] |-> $past(upd));
    assert_hit1_after_update_R7: assert property (@(posedge clk) disable iff (rst)
        hit_w[1] |-> $past(upd));

    // R2: with a nonzero divider, ticks never fall on adjacent clocks
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && cfg_div != '0) |=> (!tick || cfg_div != $past(cfg_div)));

    // R10: hold mode keeps the last enabled line level
    assert_hold_level_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(en) && !$past(rst) && cfg_idle == 2'd1) |-> line_o == $past(line_o));
endmodule

bind srt_shift_timer srt_checker #(.W(W), .DIV_BITS(DIV_BITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .cfg_div (cfg_div),
    .cfg_idle(cfg_idle),
    .tick    (tick),
    .count_o (count_o),
    .line_o  (line_o),
    .hit_w   (hit_w),
    .upd     (upd),
    .run_q   (run_q)
);

// File: tb/tb_srt_shift_timer.sv
module tb_srt_shift_timer;
    localparam int W  = 16;
    localparam int DB = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, cfg_wr = 1'b0;
    logic [DB-1:0] cfg_div = '0;
    logic [W-1:0] cfg_taps = '0, cfg_cmp0 = '0, cfg_buf0 = '0, cfg_cmp1 = '0, cfg_buf1 = '0;
    logic [1:0] cfg_swap = '0, cfg_irq_en = '0;
    logic cfg_inv_line = 1'b0, cfg_inv_compl = 1'b0;
    logic [2:0] cfg_mode_start = '0, cfg_mode_reload = '0, cfg_mode_stop = '0;
    logic [2:0] cfg_mode_shift = '0, cfg_mode_serial = '0;
    logic [1:0] cfg_idle = '0, cfg_trig0 = '0, cfg_trig1 = '0;
    logic pin_start = 1'b0, pin_reload = 1'b0, pin_stop = 1'b0, pin_shift = 1'b0, pin_serial = 1'b0;
    logic [W-1:0] count_o;
    logic line_o, line_oe, compl_o, compl_oe;
    logic [1:0] hit_o, irq_o, trig_o;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    srt_shift_timer #(.W(W), .DIV_BITS(DB)) dut (.*);

    // ---------------- reference model ----------------
    int         m_cnt;
    bit         m_s1 [5];
    bit         m_prv[5];
    logic [W-1:0] m_reg;
    bit         m_run;
    logic [W-1:0] m_cmp[2];
    logic [W-1:0] m_buf[2];
    logic [1:0] m_hit;
    bit         m_hl, m_hc;

    function automatic bit mq(logic [2:0] m, bit lvl_ok, bit c, bit p);
        if (m == 3'd1) return c && !p;
        if (m == 3'd2) return !c && p;
        if (m == 3'd3) return c != p;
        if (m == 3'd4) return lvl_ok && c;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit tk, upd, lv, cv;
        bit ev[5];
        logic [W-1:0] nx, tmp;
        logic [4:0] pv;
        logic [2:0] md[5];
        int per;
        pv = {pin_serial, pin_shift, pin_stop, pin_reload, pin_start};
        md[0] = cfg_mode_start; md[1] = cfg_mode_reload; md[2] = cfg_mode_stop;
        md[3] = cfg_mode_shift; md[4] = cfg_mode_serial;
        if (rst) begin
            m_cnt = 0; m_reg = '0; m_run = 0; m_hit = '0; m_hl = 0; m_hc = 0;
            for (int i = 0; i < 5; i++) begin m_s1[i] = 0; m_prv[i] = 0; end
            for (int k = 0; k < 2; k++) begin m_cmp[k] = '0; m_buf[k] = '0; end
        end else begin
            per = 1 << cfg_div;
            tk = en && ((m_cnt % per) == per - 1);
            m_cnt = en ? (m_cnt + 1) % 128 : 0;
            for (int i = 0; i < 5; i++) begin
                ev[i] = tk && mq(md[i], i >= 2, m_s1[i], m_prv[i]);
                if (!en || tk) m_prv[i] = m_s1[i];
                m_s1[i] = pv[i];
            end
            lv = (^(m_reg & cfg_taps)) ^ cfg_inv_line;
            cv = !(^(m_reg & cfg_taps)) ^ cfg_inv_compl;
            if (en) begin m_hl = lv; m_hc = cv; end
            upd = 0; nx = m_reg;
            if (!en) m_run = 0;
            else if (ev[2]) m_run = 0;
            else if (ev[1]) begin nx = '0; m_run = 1; upd = 1; end
            else if (ev[0]) m_run = 1;
            else if (m_run && ev[3]) begin nx = {ev[4], m_reg[W-1:1]}; upd = 1; end
            for (int k = 0; k < 2; k++) begin
                m_hit[k] = upd && (nx == m_cmp[k]);
                if (cfg_wr) begin
                    m_cmp[k] = (k == 0) ? cfg_cmp0 : cfg_cmp1;
                    m_buf[k] = (k == 0) ? cfg_buf0 : cfg_buf1;
                end else if (m_hit[k] && cfg_swap[k]) begin
                    tmp = m_cmp[k]; m_cmp[k] = m_buf[k]; m_buf[k] = tmp;
                end
            end
            m_reg = nx;
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s (phase %s) act=%h exp=%h t=%0t", req, what, tag, act, exp, $time);
        end
    endtask

    // compare every clock, 2 ns after the edge
    always @(posedge clk) begin
        bit el, ec, eoe, tx;
        logic [1:0] et;
        #2;
        tx = ^(m_reg & cfg_taps);
        eoe = 1;
        if (en) begin el = tx ^ cfg_inv_line; ec = !tx ^ cfg_inv_compl; end
        else begin
            case (cfg_idle)
                2'd0: begin el = 0; ec = 0; eoe = 0; end
                2'd1: begin el = m_hl; ec = m_hc; end
                2'd2: begin el = 0; ec = 0; end
                default: begin el = 1; ec = 1; end
            endcase
        end
        et[0] = (cfg_trig0 == 1) ? m_hit[0] : (cfg_trig0 == 2) ? m_hit[1] : (cfg_trig0 == 3) ? el : 1'b0;
        et[1] = (cfg_trig1 == 1) ? m_hit[0] : (cfg_trig1 == 2) ? m_hit[1] : (cfg_trig1 == 3) ? el : 1'b0;
        check("R3", "count_o", 32'(count_o), 32'(m_reg));
        check("R9", "line_o", 32'(line_o), 32'(el));
        check("R9", "compl_o", 32'(compl_o), 32'(ec));
        check("R10", "line_oe", 32'(line_oe), 32'(eoe));
        check("R10", "compl_oe", 32'(compl_oe), 32'(eoe));
        check("R7", "hit_o", 32'(hit_o), 32'(m_hit));
        check("R7", "irq_o", 32'(irq_o), 32'(m_hit & cfg_irq_en));
        check("R11", "trig_o", 32'(trig_o), 32'(et));
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog act=%0d exp=0", 1);
        summary();
    end

    initial begin
        logic [W-1:0] v;
        cyc(5);
        rst = 0;
        cyc(1);
        // R1: reset state, idle no-drive
        check("R1", "count after reset", 32'(count_o), 0);
        check("R1", "oe after reset", 32'(line_oe), 0);

        // R3 / R9: level shift with random serial data
        tag = "R3";
        en = 1; cfg_taps = 16'h8421; cfg_mode_shift = 3'd4; cfg_mode_serial = 3'd4;
        cfg_mode_reload = 3'd1;
        pin_reload = 1; cyc(1); pin_reload = 0;
        pin_shift = 1;
        for (int i = 0; i < 40; i++) begin pin_serial = 1'($urandom); cyc(1); end

        // R4: edge modes on shift and serial
        tag = "R4";
        cfg_mode_shift = 3'd1; cfg_mode_serial = 3'd2;
        for (int i = 0; i < 40; i++) begin pin_shift = ~pin_shift; pin_serial = 1'($urandom); cyc(1); end
        cfg_mode_shift = 3'd3; cfg_mode_serial = 3'd3;
        for (int i = 0; i < 40; i++) begin pin_shift = 1'($urandom); pin_serial = 1'($urandom); cyc(1); end
        cfg_mode_shift = 3'd2; cfg_mode_serial = 3'd1;
        for (int i = 0; i < 40; i++) begin pin_shift = ~pin_shift; pin_serial = ~pin_serial; cyc(1); end

        // R2: prescaled ticks
        tag = "R2";
        cfg_mode_shift = 3'd4; cfg_mode_serial = 3'd4; pin_shift = 1;
        cfg_div = 3'd2;
        for (int i = 0; i < 40; i++) begin pin_serial = 1'($urandom); cyc(1); end
        cfg_div = 3'd3;
        for (int i = 0; i < 40; i++) begin pin_serial = 1'($urandom); cyc(1); end
        cfg_div = 3'd0;

        // R6: stop level beats reload
        tag = "R6";
        pin_serial = 1; cyc(3);
        cfg_mode_stop = 3'd4; pin_stop = 1; cyc(3);
        v = count_o;
        pin_reload = 1; cyc(1); pin_reload = 0; cyc(5);
        check("R6", "count held under stop", 32'(count_o), 32'(v));
        check("R6", "count nonzero before reload", 32'(count_o == 0), 0);
        pin_stop = 0; cyc(3);

        // R5: level start ignored, edge start resumes, reload clears
        tag = "R5";
        cfg_mode_start = 3'd4;
        pin_start = 1; cyc(1); pin_start = 0; cyc(5);
        check("R5", "level start ignored", 32'(count_o), 32'(v));
        cfg_mode_start = 3'd1;
        pin_start = 1; cyc(1); pin_start = 0;
        for (int i = 0; i < 10; i++) begin pin_serial = 1'($urandom); cyc(1); end
        cfg_mode_shift = 3'd0;
        pin_reload = 1; cyc(1); pin_reload = 0; cyc(4);
        check("R5", "reload clears", 32'(count_o), 0);

        // R7 / R8 / R11: compare, swap, triggers
        tag = "R8";
        cfg_cmp0 = 16'hC000; cfg_buf0 = 16'hF000; cfg_cmp1 = 16'h8000; cfg_buf1 = 16'h0000;
        cfg_swap = 2'b01; cfg_irq_en = 2'b11; cfg_trig0 = 2'd1; cfg_trig1 = 2'd3;
        cfg_wr = 1; cyc(1); cfg_wr = 0;
        cfg_mode_shift = 3'd4; pin_serial = 1;
        for (int r = 0; r < 4; r++) begin
            pin_reload = 1; cyc(1); pin_reload = 0;
            cyc(20);
        end
        cfg_trig0 = 2'd2; cfg_swap = 2'b11; cfg_irq_en = 2'b10;
        for (int r = 0; r < 3; r++) begin
            pin_reload = 1; cyc(1); pin_reload = 0;
            cyc(18);
        end

        // R9: polarity controls
        tag = "R9";
        for (int p = 0; p < 4; p++) begin
            cfg_inv_line = p[0]; cfg_inv_compl = p[1]; cfg_taps = 16'($urandom);
            for (int i = 0; i < 12; i++) begin pin_serial = 1'($urandom); cyc(1); end
        end

        // R12 / R10: disabled behaviour
        tag = "R12";
        en = 0; cfg_idle = 2'd1; cyc(1);
        v = count_o;
        for (int i = 0; i < 10; i++) begin pin_shift = ~pin_shift; pin_reload = ~pin_reload; cyc(1); end
        check("R12", "frozen when disabled", 32'(count_o), 32'(v));
        tag = "R10";
        cfg_idle = 2'd3; cyc(2);
        check("R10", "idle high line", 32'(line_o), 1);
        check("R10", "idle high compl", 32'(compl_o), 1);
        cfg_idle = 2'd0; cyc(2);
        check("R10", "idle no-drive oe", 32'(line_oe), 0);
        cfg_idle = 2'd2; cyc(2);
        check("R10", "idle low line", 32'(line_o), 0);
        pin_reload = 0; pin_shift = 1; en = 1; cyc(5);

        // random phases
        tag = "RND";
        for (int ph = 0; ph < 20; ph++) begin
            cfg_div = 3'($urandom % 4);
            cfg_mode_start = 3'($urandom); cfg_mode_reload = 3'($urandom);
            cfg_mode_stop = 3'($urandom % 6); cfg_mode_shift = 3'($urandom);
            cfg_mode_serial = 3'($urandom);
            cfg_idle = 2'($urandom); cfg_trig0 = 2'($urandom); cfg_trig1 = 2'($urandom);
            cfg_swap = 2'($urandom); cfg_irq_en = 2'($urandom);
            cfg_inv_line = 1'($urandom); cfg_inv_compl = 1'($urandom);
            cfg_taps = 16'($urandom);
            cfg_cmp0 = (ph % 2) ? 16'h8000 : 16'h0000; cfg_buf0 = 16'hC000;
            cfg_cmp1 = 16'hFFFF; cfg_buf1 = 16'h4000;
            cfg_wr = 1; cyc(1); cfg_wr = 0;
            for (int i = 0; i < 200; i++) begin
                pin_start  = ($urandom % 16) == 0;
                pin_reload = ($urandom % 24) == 0;
                pin_stop   = ($urandom % 20) == 0;
                pin_shift  = 1'($urandom);
                pin_serial = ($urandom % 4) != 0;
                if (($urandom % 50) == 0) en = ~en;
                cyc(1);
            end
            en = 1;
        end
        cyc(2);
        summary();
    end
endmodule